// File: doc/BRIEF.md
# Double-Buffered Dual DAC Loader

This block is the digital front end of a two-channel, 12-bit converter, loaded from an 8-bit host bus. The host writes each channel's word in two pieces, a low byte and a high nibble, into a per-channel staging register. The pieces can arrive in either order. Writing to staging never disturbs the converter codes. A shared active-low load strobe copies both staging words into the two code registers at the same moment. This gives glitch-free simultaneous updates.

All host strobes, the address and the data are asynchronous to the block clock. They pass together through a two-stage synchronising pipeline, so the data stays aligned with its strobes. The load strobe acts as a level: while it is held low, the code registers follow the staging registers. They keep whatever was present when it returns high. A small monitor measures how long the load strobe stays low after a write that overlapped it. If the pulse ends before a programmable number of cycles, the monitor raises a sticky error flag.

Top module: `dual_dac_loader`

## Requirements
- R1: The address selects the target piece: `addr`=0 is channel A low byte, 1 is channel A high nibble, 2 is channel B low byte, 3 is channel B high nibble.
- R2: A staging register changes only while `cs_n` and `wr_n` are both low. A write with either one high leaves both staging words unchanged, which a later load makes visible.
- R3: A high-nibble write places `data[3:0]` into word bits 11..8. A low-byte write places `data[7:0]` into bits 7..0. The other bits of the word are kept.
- R4: While `ld_n` is high, the outputs `dac_a` and `dac_b` do not change, whatever is written and in whichever order the two pieces arrive.
- R5: While the synchronised `ld_n` is low, both outputs take their staging words every cycle. After `ld_n` rises, they hold the staging words present in the last low cycle.
- R6: A load works whatever the levels of `cs_n` and `wr_n`.
- R7: A write that happens while the load is low arms the monitor. Each later cycle that has the load low and no write counts as one gap cycle. When the load rises, an armed monitor with fewer than `min_gap` gap cycles sets `overlap_err`. The flag stays at 1 until reset.
- R8: Reset (`rst_n` low) clears both staging words, both outputs and `overlap_err` to zero.
- R9: If a write and a load are active in the same synchronised cycle, the outputs take the staging words from before that write. The written value reaches the outputs one cycle later, provided the load is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Piece select (channel, high/low) |
| data | input | 8 | Host data bus, right-justified |
| ld_n | input | 1 | Active-low common load strobe |
| min_gap | input | 8 | Minimum load-low cycles required after an overlapping write |
| dac_a | output | 12 | Channel A code register |
| dac_b | output | 12 | Channel B code register |
| overlap_err | output | 1 | Sticky overlap violation flag |

## Verification
Properties check four things on every cycle:
- a staging word holds whenever no write is active;
- a nibble write lands in bits 11..8;
- the outputs are frozen while the load is high;
- the outputs take the previous cycle's staging words while the load is low, which covers the write-and-load case.

The error flag is also checked every cycle to confirm it never falls. The following behaviours show up only in the bench's scenarios, which sweep many word values in both write orders:
- the end-to-end address decode;
- ignored writes, made visible by a later load;
- loads issued with chip select still asserted;
- the threshold behaviour of the overlap monitor, with gaps either side of `min_gap`;
- the reset clearing everything.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  localparam int WORD_W  = 12;
  localparam int BUS_W   = 8;
  localparam int HI_W    = WORD_W - BUS_W;
  localparam int NUM_CH  = 2;
  localparam int ADDR_W  = 2;
  localparam int GAP_W   = 8;
  localparam int SYNC_N  = 2;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dac_sync_pipe.sv
module dac_sync_pipe #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dac_input_stage.sv
module dac_input_stage
  import dac_loader_pkg::*;
#(
  parameter int CH_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  data,
  output word_t             word
);
  localparam logic CH_BIT = CH_ID[0];

  word_t word_q, word_d;
  logic  sel_ch, sel_hi;

  assign sel_ch = wr_act && (addr[1] == CH_BIT);
  assign sel_hi = addr[0];

  always_comb begin
    word_d = word_q;
    if (sel_ch) begin
      if (sel_hi) word_d[WORD_W-1:BUS_W] = data[HI_W-1:0];
      else        word_d[BUS_W-1:0]      = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (sel_ch) word_q <= word_d;
  end

  assign word = word_q;

  // R2: no write selecting this channel, no change
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ch |=> $stable(word_q));

  // R3: nibble write lands in the top bits, right-justified from the bus
  p_nibble_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ch && sel_hi) |=> word_q[WORD_W-1:BUS_W] == $past(data[HI_W-1:0]));

  // R3: byte write keeps the top bits
  p_byte_keeps_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ch && !sel_hi) |=> $stable(word_q[WORD_W-1:BUS_W]));
endmodule

// File: rtl/dac_overlap_mon.sv
module dac_overlap_mon
  import dac_loader_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_act,
  input  logic             ld_act,
  input  logic [GAP_W-1:0] min_gap,
  output logic             err
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic             ld_prev_q;
  logic             armed_q, armed_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             err_q, err_d;
  logic             ld_rise;

  assign ld_rise = ld_prev_q && !ld_act;

  always_comb begin
    armed_d = armed_q;
    gap_d   = gap_q;
    err_d   = err_q;
    if (ld_rise) begin
      if (armed_q && (gap_q < min_gap)) err_d = 1'b1;
      armed_d = 1'b0;
      gap_d   = '0;
    end else if (ld_act) begin
      if (wr_act) begin
        armed_d = 1'b1;
        gap_d   = '0;
      end else if (gap_q != GAP_MAX) begin
        gap_d = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_prev_q <= 1'b0;
      armed_q   <= 1'b0;
      gap_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      ld_prev_q <= ld_act;
      armed_q   <= armed_d;
      gap_q     <= gap_d;
      err_q     <= err_d;
    end
  end

  assign err = err_q;

  // R7: the violation flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7: the flag only rises on the cycle after a load rising edge
  p_err_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(ld_rise));
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dac_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  data,
  input  logic              ld_n,
  input  logic [GAP_W-1:0]  min_gap,
  output logic [WORD_W-1:0] dac_a,
  output logic [WORD_W-1:0] dac_b,
  output logic              overlap_err
);
  localparam int PIPE_W = 3 + ADDR_W + BUS_W;
  localparam logic [PIPE_W-1:0] PIPE_RST = {3'b111, {(ADDR_W+BUS_W){1'b0}}};

  logic [PIPE_W-1:0] pipe_d, pipe_q;
  logic              cs_s, wr_s, ld_s;
  logic [ADDR_W-1:0] addr_s;
  logic [BUS_W-1:0]  data_s;
  logic              wr_act, ld_act;

  assign pipe_d = {cs_n, wr_n, ld_n, addr, data};

  dac_sync_pipe #(
    .W(PIPE_W), .STAGES(SYNC_N), .RST_VAL(PIPE_RST)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pipe_d), .q(pipe_q)
  );

  assign {cs_s, wr_s, ld_s, addr_s, data_s} = pipe_q;
  assign wr_act = !cs_s && !wr_s;
  assign ld_act = !ld_s;

  word_t stage_w [NUM_CH];
  word_t out_q   [NUM_CH];
  word_t out_d   [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dac_input_stage #(.CH_ID(ch)) u_stage (
      .clk(clk), .rst_n(rst_n), .wr_act(wr_act),
      .addr(addr_s), .data(data_s), .word(stage_w[ch])
    );

    always_comb begin
      out_d[ch] = out_q[ch];
      if (ld_act) out_d[ch] = stage_w[ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q[ch] <= '0;
      else if (ld_act) out_q[ch] <= out_d[ch];
    end
  end

  dac_overlap_mon u_mon (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .ld_act(ld_act),
    .min_gap(min_gap), .err(overlap_err)
  );

  assign dac_a = out_q[0];
  assign dac_b = out_q[NUM_CH-1];

  // R4: outputs frozen while load is inactive
  p_out_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_act |=> ($stable(dac_a) && $stable(dac_b)));

  // R5, R9: load copies the staging words seen before any same-cycle write
  p_load_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_act |=> (dac_a == $past(stage_w[0]) && dac_b == $past(stage_w[NUM_CH-1])));
endmodule

// File: tb/dual_dac_loader_test.sv
`timescale 1ns/1ps
module dual_dac_loader_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, wr_n, ld_n;
  logic [1:0]  addr;
  logic [7:0]  data;
  logic [7:0]  min_gap;
  logic [11:0] dac_a, dac_b;
  logic        overlap_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_dac_loader uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .data(data), .ld_n(ld_n), .min_gap(min_gap), .dac_a(dac_a),
    .dac_b(dac_b), .overlap_err(overlap_err)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_write(input logic [1:0] a, input logic [7:0] v,
                             input logic c, input logic w);
    @(negedge clk);
    addr = a; data = v; cs_n = c; wr_n = w;
    idle(3);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic put_word(input int ch, input logic [11:0] v, input bit hi_first);
    logic [1:0] base;
    base = ch[0] ? 2'd2 : 2'd0;
    if (hi_first) begin
      drive_write(base | 2'd1, {4'h0, v[11:8]}, 1'b0, 1'b0); idle(3);
      drive_write(base, v[7:0], 1'b0, 1'b0);                 idle(3);
    end else begin
      drive_write(base, v[7:0], 1'b0, 1'b0);                 idle(3);
      drive_write(base | 2'd1, {4'h0, v[11:8]}, 1'b0, 1'b0); idle(3);
    end
  endtask

  task automatic pulse_load(input logic cs_during);
    @(negedge clk);
    cs_n = cs_during; ld_n = 1'b0;
    idle(3);
    ld_n = 1'b1; cs_n = 1'b1;
    idle(4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [11:0] prev_a, prev_b, va, vb;
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
    addr = '0; data = '0; min_gap = 8'd4;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R8: reset state
    check({4'h0, dac_a}, 16'h0, "R8 dac_a reset");
    check({4'h0, dac_b}, 16'h0, "R8 dac_b reset");
    check({15'h0, overlap_err}, 16'h0, "R8 flag reset");

    prev_a = '0; prev_b = '0;
    for (int i = 0; i < 16; i++) begin
      va = 12'((i * 1237 + 291) & 12'hFFF);
      vb = 12'((i * 2731 + 1000) & 12'hFFF);
      put_word(0, va, i[0]);
      put_word(1, vb, ~i[0]);
      // R4: staging writes alone leave outputs unchanged
      check({4'h0, dac_a}, {4'h0, prev_a}, "R4 dac_a held");
      check({4'h0, dac_b}, {4'h0, prev_b}, "R4 dac_b held");
      // R6: on odd-pair iterations load with chip select asserted
      pulse_load(i[1] ? 1'b0 : 1'b1);
      // R1, R3, R5: both channels updated with assembled words
      check({4'h0, dac_a}, {4'h0, va}, "R1 R3 R5 dac_a loaded");
      check({4'h0, dac_b}, {4'h0, vb}, "R1 R3 R5 dac_b loaded");
      prev_a = va; prev_b = vb;
    end

    // R2: writes with only one strobe low are ignored
    drive_write(2'd0, 8'h5A, 1'b1, 1'b0); idle(3);
    drive_write(2'd3, 8'h07, 1'b0, 1'b1); idle(3);
    pulse_load(1'b1);
    check({4'h0, dac_a}, {4'h0, prev_a}, "R2 cs high ignored");
    check({4'h0, dac_b}, {4'h0, prev_b}, "R2 wr high ignored");

    // R3: high nibble keeps the low byte, upper bus bits dropped
    drive_write(2'd1, 8'hF9, 1'b0, 1'b0); idle(3);
    pulse_load(1'b1);
    check({4'h0, dac_a}, {4'h0, 4'h9, prev_a[7:0]}, "R3 nibble only");
    prev_a = {4'h9, prev_a[7:0]};

    // R7: overlapping write with long tail -> no violation
    @(negedge clk); ld_n = 1'b0; idle(2);
    drive_write(2'd2, 8'hC3, 1'b0, 1'b0);
    idle(8);
    ld_n = 1'b1; idle(5);
    check({15'h0, overlap_err}, 16'h0, "R7 long tail no flag");
    // R5: write during load reaches output
    check({4'h0, dac_b}, {4'h0, prev_b[11:8], 8'hC3}, "R5 transparent load");
    prev_b = {prev_b[11:8], 8'hC3};

    // R7: exactly min_gap tail -> no violation
    @(negedge clk); ld_n = 1'b0; idle(2);
    drive_write(2'd2, 8'h11, 1'b0, 1'b0);
    idle(4);
    ld_n = 1'b1; idle(5);
    check({15'h0, overlap_err}, 16'h0, "R7 tail equal to min_gap");

    // R7: short tail -> violation
    @(negedge clk); ld_n = 1'b0; idle(2);
    drive_write(2'd2, 8'h22, 1'b0, 1'b0);
    idle(2);
    ld_n = 1'b1; idle(5);
    check({15'h0, overlap_err}, 16'h1, "R7 short tail flagged");

    // R7: sticky through a clean load
    pulse_load(1'b1);
    check({15'h0, overlap_err}, 16'h1, "R7 flag sticky");

    // R8: reset clears everything
    do_reset();
    check({4'h0, dac_a}, 16'h0, "R8 dac_a cleared");
    check({4'h0, dac_b}, 16'h0, "R8 dac_b cleared");
    check({15'h0, overlap_err}, 16'h0, "R8 flag cleared");
    pulse_load(1'b1);
    check({4'h0, dac_a}, 16'h0, "R8 staging A cleared");
    check({4'h0, dac_b}, 16'h0, "R8 staging B cleared");

    // R9: write and load together; final value follows one cycle later
    @(negedge clk);
    addr = 2'd0; data = 8'h3C; cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0;
    idle(3);
    cs_n = 1'b1; wr_n = 1'b1;
    idle(1);
    ld_n = 1'b1;
    idle(5);
    check({4'h0, dac_a}, 16'h003C, "R9 same-cycle write then load");

    done = 1;
    report();
  end
endmodule